// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This block turns a stream of 8-bit-per-channel red, green, blue and alpha pixels into 32-bit memory words in one of twelve output layouts. A 4-bit format code picks the bit depth (16-bit 4444 or 565, 24-bit 888, 32-bit 8888) and the order of the channels. Pixels whose packed size does not divide the word are joined byte by byte, so 16-bit pixels pair up inside a word and 24-bit pixels run across word boundaries. The result goes out as a word with a 4-bit byte strobe and a flag that marks the final word of a line.

The alpha field is either taken from the input, optionally inverted, or filled with a constant whose bits are all the complement of the inversion control. A lane mask clears the byte strobes of chosen byte positions in every word, which lets a writer leave those bytes in memory untouched. Format codes without a defined layout make the block drop the pixels it accepts and raise an error flag. Configuration is expected to stay fixed while a line is in flight.

Both sides use a valid/ready handshake. The input pixel carries an end-of-line marker. When that marker arrives, the block flushes any partly filled word so that no bytes are held over into the next line.

Top module: `pix_pack_top`

## Requirements
- R1: Codes 0, 1, 2 and 3 give 16-bit 4444 pixels. Reading from the most significant nibble down, their channel order is A,B,G,R (0), A,R,G,B (1), B,G,R,A (2) and R,G,B,A (3). Each field holds the top 4 bits of its 8-bit channel.
- R2: Codes 6 and 7 give 16-bit 565 pixels, ordered B,G,R (6) and R,G,B (7) from the most significant bit down. The outer fields take the top 5 bits of their channels and the middle green field takes the top 6 bits.
- R3: Codes 12, 13, 14 and 15 give 32-bit pixels ordered A,B,G,R / A,R,G,B / B,G,R,A / R,G,B,A from byte 3 down to byte 0, one pixel per word.
- R4: Codes 8 and 9 give 24-bit pixels ordered B,G,R (8) and R,G,B (9) from byte 2 down to byte 0. The bytes of consecutive pixels fill the words in order with no gaps, so four pixels make exactly three words.
- R5: In the 16-bit layouts two pixels share one word, and the earlier pixel sits in bits 15:0.
- R6: With alpha storing on, the alpha field carries the input alpha, bitwise inverted when the inversion control is 1.
- R7: With alpha storing off, every bit of the alpha field equals the complement of the inversion control (all ones when it is 0, all zeros when it is 1).
- R8: Bit k of the lane mask gates the strobe of byte k in every word. Masking a lane clears its strobe and leaves the data byte as it would otherwise be.
- R9: A pixel marked end-of-line closes the line. A partly filled word is emitted with strobes only for its filled bytes (subject to the lane mask), with zeros in the unfilled bytes and with the last flag set. If the bytes exactly fill a word, that word carries the last flag. A 24-bit pixel that overflows a word produces a full word followed by a last partial word.
- R10: Codes 4, 5, 10 and 11 drive the error flag high. Pixels accepted under those codes produce no output word. The error flag is low for all other codes.
- R11: While a word is offered and not taken, the word, its strobes and its last flag stay unchanged, and no pixel is lost or repeated under any pattern of output stalls.
- R12: During and right after reset no word is offered, and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Output format code |
| cfg_alpha_keep | input | 1 | 1: store input alpha; 0: fill alpha field |
| cfg_alpha_inv | input | 1 | Invert stored alpha / select fill value |
| cfg_lane_en | input | 4 | Per-byte-lane store enable mask |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed word |
| out_strb | output | 4 | Byte strobes |
| out_last | output | 1 | Final word of the line |
| fmt_err | output | 1 | Current format code is unsupported |

## Verification
The bench runs lines through every valid code and puts a scoreboard model of the byte stream against the words that come out. It targets the 24-bit layouts at line lengths of two, four and five pixels. A packer that mishandled the carry across words would lose or reorder bytes there, or leave off the second word when one pixel overflows a word at end of line. Odd-length 16-bit lines check that the lone final half-word gets only two strobes and the last flag. Lane masks and random output stalls are applied to the same streams, which would expose strobes that leak into masked lanes or a word that changes while stalled. Unsupported codes are fed whole lines, and any stray word or a missing error flag counts as a failure.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int CH_W   = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANES * 8;
    localparam int RES_W  = (LANES - 1) * 8;
    localparam int COMB_W = WORD_W + RES_W;
    localparam int CNT_W  = $clog2(2 * LANES);

    typedef enum logic [1:0] {
        DEP_4444 = 2'd0,
        DEP_565  = 2'd1,
        DEP_888  = 2'd2,
        DEP_8888 = 2'd3
    } depth_e;

    typedef struct packed {
        logic [RES_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              flush;
        logic [WORD_W-1:0] o_data;
        logic [LANES-1:0]  o_strb;
        logic              o_last;
        logic              o_valid;
    } pack_state_t;

endpackage

// File: rtl/pp_fmt_decode.sv
module pp_fmt_decode
    import pp_pkg::*;
(
    input  logic [3:0]       fmt,
    output depth_e           depth,
    output logic [1:0]       order,
    output logic [CNT_W-1:0] nbytes,
    output logic             bad
);

    always_comb begin
        depth = depth_e'(fmt[3:2]);
        bad   = ((fmt[3:2] == 2'b01) && !fmt[1]) ||
                ((fmt[3:2] == 2'b10) &&  fmt[1]);
        // three-channel layouts reuse the lower three slots of order 0/1
        order = (depth == DEP_565 || depth == DEP_888) ? {1'b0, fmt[0]} : fmt[1:0];
        unique case (depth)
            DEP_4444, DEP_565: nbytes = CNT_W'(2);
            DEP_888:           nbytes = CNT_W'(3);
            default:           nbytes = CNT_W'(4);
        endcase
        if (bad) nbytes = '0;
    end

endmodule

// File: rtl/pp_pixel_encode.sv
module pp_pixel_encode
    import pp_pkg::*;
(
    input  logic [CH_W-1:0]   r,
    input  logic [CH_W-1:0]   g,
    input  logic [CH_W-1:0]   b,
    input  logic [CH_W-1:0]   a,
    input  depth_e            depth,
    input  logic [1:0]        order,
    input  logic              alpha_keep,
    input  logic              alpha_inv,
    output logic [WORD_W-1:0] pix
);

    logic [CH_W-1:0] alpha_v;
    logic [CH_W-1:0] ch3, ch2, ch1, ch0;

    always_comb begin
        if (alpha_keep) alpha_v = alpha_inv ? ~a : a;
        else            alpha_v = {CH_W{~alpha_inv}};

        unique case (order)
            2'd0:    begin ch3 = alpha_v; ch2 = b; ch1 = g; ch0 = r;       end
            2'd1:    begin ch3 = alpha_v; ch2 = r; ch1 = g; ch0 = b;       end
            2'd2:    begin ch3 = b;       ch2 = g; ch1 = r; ch0 = alpha_v; end
            default: begin ch3 = r;       ch2 = g; ch1 = b; ch0 = alpha_v; end
        endcase

        unique case (depth)
            DEP_4444: pix = {16'h0, ch3[7:4], ch2[7:4], ch1[7:4], ch0[7:4]};
            DEP_565:  pix = {16'h0, ch2[7:3], ch1[7:2], ch0[7:3]};
            DEP_888:  pix = {8'h0, ch2, ch1, ch0};
            default:  pix = {ch3, ch2, ch1, ch0};
        endcase
    end

endmodule

// File: rtl/pp_byte_packer.sv
module pp_byte_packer
    import pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pix,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              eol,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LANES-1:0]  lane_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb,
    output logic              out_last
);

    localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

    pack_state_t       s_d, s_q;
    logic              slot_free;
    logic [CNT_W-1:0]  total;
    logic [COMB_W-1:0] merged;

    function automatic logic [LANES-1:0] low_mask(input logic [CNT_W-1:0] k);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(k));
        return m;
    endfunction

    always_comb begin
        s_d       = s_q;
        slot_free = !s_q.o_valid || out_ready;
        total     = s_q.cnt + nbytes;
        merged    = {{WORD_W{1'b0}}, s_q.acc} |
                    ({{RES_W{1'b0}}, pix} << {s_q.cnt, 3'b000});

        if (s_q.o_valid && out_ready) s_d.o_valid = 1'b0;

        if (s_q.flush) begin
            if (slot_free) begin
                s_d.o_data  = {{(WORD_W-RES_W){1'b0}}, s_q.acc};
                s_d.o_strb  = low_mask(s_q.cnt) & lane_en;
                s_d.o_last  = 1'b1;
                s_d.o_valid = 1'b1;
                s_d.acc     = '0;
                s_d.cnt     = '0;
                s_d.flush   = 1'b0;
            end
        end else if (in_valid && slot_free && nbytes != '0) begin
            if (total >= LANES_C) begin
                s_d.o_data  = merged[WORD_W-1:0];
                s_d.o_strb  = lane_en;
                s_d.o_last  = eol && (total == LANES_C);
                s_d.o_valid = 1'b1;
                s_d.acc     = merged[COMB_W-1:WORD_W];
                s_d.cnt     = total - LANES_C;
                s_d.flush   = eol && (total > LANES_C);
            end else if (eol) begin
                s_d.o_data  = merged[WORD_W-1:0];
                s_d.o_strb  = low_mask(total) & lane_en;
                s_d.o_last  = 1'b1;
                s_d.o_valid = 1'b1;
                s_d.acc     = '0;
                s_d.cnt     = '0;
            end else begin
                s_d.acc     = merged[RES_W-1:0];
                s_d.cnt     = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = !s_q.o_valid || out_ready ? !s_q.flush : 1'b0;
    assign out_valid = s_q.o_valid;
    assign out_data  = s_q.o_data;
    assign out_strb  = s_q.o_strb;
    assign out_last  = s_q.o_last;

endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
    import pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_fmt,
    input  logic              cfg_alpha_keep,
    input  logic              cfg_alpha_inv,
    input  logic [LANES-1:0]  cfg_lane_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_r,
    input  logic [CH_W-1:0]   in_g,
    input  logic [CH_W-1:0]   in_b,
    input  logic [CH_W-1:0]   in_a,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb,
    output logic              out_last,
    output logic              fmt_err
);

    depth_e            depth;
    logic [1:0]        order;
    logic [CNT_W-1:0]  nbytes;
    logic [WORD_W-1:0] pix;

    pp_fmt_decode u_dec (
        .fmt    (cfg_fmt),
        .depth  (depth),
        .order  (order),
        .nbytes (nbytes),
        .bad    (fmt_err)
    );

    pp_pixel_encode u_enc (
        .r          (in_r),
        .g          (in_g),
        .b          (in_b),
        .a          (in_a),
        .depth      (depth),
        .order      (order),
        .alpha_keep (cfg_alpha_keep),
        .alpha_inv  (cfg_alpha_inv),
        .pix        (pix)
    );

    pp_byte_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix       (pix),
        .nbytes    (nbytes),
        .eol       (in_eol),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .lane_en   (cfg_lane_en),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_strb  (out_strb),
        .out_last  (out_last)
    );

endmodule

// File: rtl/pp_checker.sv
module pp_checker
    import pp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [LANES-1:0]  cfg_lane_en,
    input logic              fmt_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [LANES-1:0]  out_strb,
    input logic              out_last
);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_strb) && $stable(out_last)));

    p_lane_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_strb & ~cfg_lane_en) == '0));

    p_partial_is_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_lane_en == '1 && out_strb != '1) |-> out_last);

    p_strb_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_lane_en == '1) |->
            (out_strb == 4'b0001 || out_strb == 4'b0011 ||
             out_strb == 4'b0111 || out_strb == 4'b1111));

    p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_err && in_ready && !out_valid) |=> !out_valid);

    p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

endmodule

bind pix_pack_top pp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .cfg_lane_en (cfg_lane_en),
    .fmt_err     (fmt_err),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_strb    (out_strb),
    .out_last    (out_last)
);

// File: tb/tb_pix_pack_top.sv
module tb_pix_pack_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_fmt;
    logic        cfg_alpha_keep, cfg_alpha_inv;
    logic [3:0]  cfg_lane_en;
    logic        in_valid, in_ready, in_eol;
    logic [7:0]  in_r, in_g, in_b, in_a;
    logic        out_valid, out_ready, out_last;
    logic [31:0] out_data;
    logic [3:0]  out_strb;
    logic        fmt_err;

    int compared = 0;
    int mismatched = 0;
    bit stall = 1'b0;
    bit done = 1'b0;

    logic [36:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  mq[$];

    always #10 clk = ~clk;

    pix_pack_top dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // independent expectation: {nbytes, value}
    function automatic logic [35:0] bexp(input logic [3:0] code, input logic [7:0] r, g, b, a,
                                         input bit keep, input bit inv);
        logic [7:0] al;
        al = keep ? (inv ? ~a : a) : (inv ? 8'h00 : 8'hFF);
        case (code)
            4'd0:  return {4'd2, 16'h0, al[7:4], b[7:4], g[7:4], r[7:4]};
            4'd1:  return {4'd2, 16'h0, al[7:4], r[7:4], g[7:4], b[7:4]};
            4'd2:  return {4'd2, 16'h0, b[7:4], g[7:4], r[7:4], al[7:4]};
            4'd3:  return {4'd2, 16'h0, r[7:4], g[7:4], b[7:4], al[7:4]};
            4'd6:  return {4'd2, 16'h0, b[7:3], g[7:2], r[7:3]};
            4'd7:  return {4'd2, 16'h0, r[7:3], g[7:2], b[7:3]};
            4'd8:  return {4'd3, 8'h0, b, g, r};
            4'd9:  return {4'd3, 8'h0, r, g, b};
            4'd12: return {4'd4, al, b, g, r};
            4'd13: return {4'd4, al, r, g, b};
            4'd14: return {4'd4, b, g, r, al};
            4'd15: return {4'd4, r, g, b, al};
            default: return 36'h0;
        endcase
    endfunction

    task automatic push_word(input int k, input bit last, input string tag);
        logic [31:0] w;
        logic [3:0]  s;
        w = '0;
        s = '0;
        for (int i = 0; i < k; i++) begin
            w[8*i +: 8] = mq.pop_front();
            s[i] = 1'b1;
        end
        exp_q.push_back({w, s & cfg_lane_en, last});
        tag_q.push_back(tag);
    endtask

    task automatic send_px(input logic [7:0] r, g, b, a, input bit eol, input string tag);
        logic [35:0] e;
        int nb;
        e  = bexp(cfg_fmt, r, g, b, a, cfg_alpha_keep, cfg_alpha_inv);
        nb = int'(e[35:32]);
        for (int i = 0; i < nb; i++) mq.push_back(e[8*i +: 8]);
        while (mq.size() >= 4) push_word(4, eol && mq.size() == 4, tag);
        if (eol && mq.size() > 0) push_word(mq.size(), 1'b1, tag);
        in_r = r; in_g = g; in_b = b; in_a = a; in_eol = eol; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_line(input int npix, input int seed, input string tag);
        for (int i = 0; i < npix; i++)
            send_px(8'(seed * 29 + i * 53 + 7), 8'(seed * 11 + i * 97 + 130),
                    8'(seed * 71 + i * 19 + 60), 8'(seed * 5 + i * 41 + 200),
                    i == npix - 1, tag);
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || out_valid);
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [3:0] code, input bit keep, input bit inv, input logic [3:0] lane);
        drain();
        cfg_fmt = code; cfg_alpha_keep = keep; cfg_alpha_inv = inv; cfg_lane_en = lane;
    endtask

    // output ready pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected word", {27'h0, out_data, out_strb, out_last}, 64'h0);
                end else begin
                    logic [36:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_data, out_strb, out_last} === e, t, "word/strb/last",
                        {27'h0, out_data, out_strb, out_last}, {27'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0;
        in_r = '0; in_g = '0; in_b = '0; in_a = '0;
        cfg_fmt = 4'd13; cfg_alpha_keep = 1'b1; cfg_alpha_inv = 1'b0; cfg_lane_en = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid in reset", 64'(out_valid), 64'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12", "in_ready after reset", 64'(in_ready), 64'h1);
        chk(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'h0);
        @(posedge clk);
        #1;

        // R10 decode of every code
        for (int c = 0; c < 16; c++) begin
            cfg_fmt = 4'(c);
            #1;
            chk(fmt_err == (c == 4 || c == 5 || c == 10 || c == 11), "R10", "fmt_err",
                64'(fmt_err), 64'(c == 4 || c == 5 || c == 10 || c == 11));
        end

        // R3 / R6: 32-bit layouts, alpha stored and inverted
        for (int c = 12; c < 16; c++) begin
            set_cfg(4'(c), 1'b1, 1'b0, 4'hF); send_line(3, c, "R3");
            set_cfg(4'(c), 1'b1, 1'b1, 4'hF); send_line(2, c + 1, "R6");
        end
        // R7: fill value from the inversion control
        set_cfg(4'd13, 1'b0, 1'b0, 4'hF); send_line(2, 3, "R7");
        set_cfg(4'd15, 1'b0, 1'b1, 4'hF); send_line(2, 4, "R7");
        set_cfg(4'd0,  1'b0, 1'b1, 4'hF); send_line(2, 5, "R7");
        set_cfg(4'd2,  1'b0, 1'b0, 4'hF); send_line(2, 6, "R7");

        // R1 / R5 / R9: 4444, odd lines leave a half word
        for (int c = 0; c < 4; c++) begin
            set_cfg(4'(c), 1'b1, 1'b1, 4'hF); send_line(3, c + 9, "R1");
            set_cfg(4'(c), 1'b1, 1'b0, 4'hF); send_line(4, c + 2, "R5");
        end
        // R2: 565
        for (int c = 6; c < 8; c++) begin
            set_cfg(4'(c), 1'b1, 1'b0, 4'hF); send_line(4, c, "R2");
            send_line(1, c + 20, "R9");
        end

        // R4 / R9: 24-bit byte carry at several line lengths
        for (int c = 8; c < 10; c++) begin
            set_cfg(4'(c), 1'b1, 1'b0, 4'hF);
            send_line(4, c, "R4");
            send_line(5, c + 3, "R4");
            send_line(2, c + 5, "R9");
            send_line(3, c + 7, "R9");
            send_line(1, c + 8, "R9");
        end

        // R8: lane masks
        set_cfg(4'd13, 1'b1, 1'b0, 4'b0101); send_line(3, 30, "R8");
        set_cfg(4'd7,  1'b1, 1'b0, 4'b1010); send_line(3, 31, "R8");
        set_cfg(4'd9,  1'b1, 1'b0, 4'b0110); send_line(5, 32, "R8");

        // R11: random output stalls over mixed layouts
        stall = 1'b1;
        set_cfg(4'd8,  1'b1, 1'b0, 4'hF); send_line(9, 40, "R11");
        set_cfg(4'd1,  1'b1, 1'b1, 4'hF); send_line(7, 41, "R11");
        set_cfg(4'd14, 1'b0, 1'b0, 4'hF); send_line(6, 42, "R11");
        set_cfg(4'd6,  1'b1, 1'b0, 4'b0011); send_line(5, 43, "R11");
        set_cfg(4'd9,  1'b1, 1'b0, 4'hF); send_line(6, 44, "R11");
        stall = 1'b0;

        // R10: unsupported codes emit nothing
        set_cfg(4'd5, 1'b1, 1'b0, 4'hF);
        #1;
        chk(fmt_err == 1'b1, "R10", "fmt_err code 5", 64'(fmt_err), 64'h1);
        send_line(3, 50, "R10");
        repeat (4) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10", "no word for code 5", 64'(out_valid), 64'h0);
        end
        set_cfg(4'd10, 1'b1, 1'b0, 4'hF);
        send_line(4, 51, "R10");
        repeat (4) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10", "no word for code 10", 64'(out_valid), 64'h0);
        end

        // back to a valid code: nothing stale leaks in
        set_cfg(4'd12, 1'b1, 1'b0, 4'hF); send_line(2, 60, "R3");
        drain();
        chk(exp_q.size() == 0, "R11", "scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        summary();
    end

endmodule